// File: doc/BRIEF.md
# USB Core Clock Freeze and Wakeup Controller

This block sits beside a USB device core and lets software stop that core's clock to save power. A freeze bit in a general control register turns off a glitch-free clock gate, so the core logic sees no edges while it is set. A small register window stays fully usable during the freeze: the general control register, a device control register, the interrupt flag and enable registers, and a pointer/data pair that reads and writes a small scratch memory with an auto-incrementing address. A core-side configuration register in the same address space is not reachable while frozen.

Interrupt flags from the core are recorded only while the core clock runs. While frozen, the only source that can still raise a flag is bus activity: it is caught by an asynchronously set capture flop, carried into the register clock domain through a two-flop synchronizer, and then shown as the wake flag. The interrupt output combines each flag with its enable bit. A CPU wake output follows the interrupt output in idle mode, and in power-down mode responds only to the wake source, including straight from the asynchronous capture before any clock edge.

Top module: `usbfrz_ctrl`

## Requirements
- R1: After reset all registers read 0, `irq` and `cpu_wake` are 0 and `core_clk` follows `clk`.
- R2: Bit 0 of offset 0 is the freeze bit; while it is 1 `core_clk` has no rising edge from the clock high phase after the write, and clearing it restores one `core_clk` edge per `clk` edge; other bits of offset 0 read 0.
- R3: Offsets 0 (general control), 1 (device control, 8 bits), 2 (flags), 3 (enables) and 4/5 (memory pointer and data) are readable and writable whether or not the freeze bit is set.
- R4: Offset 6 is an 8-bit core configuration register; while frozen, writes to it are ignored and it reads 0, and after unfreeze it reads its stored value.
- R5: Flag bits [NSRC-1:0] at offset 2 are set by a `core_evt` bit high at a clock edge while not frozen; `core_evt` has no effect while frozen.
- R6: A rising edge on `bus_activity` sets flag bit 7 (wake) exactly on the third `clk` rising edge after it, frozen or not; the flag stays set after `bus_activity` falls.
- R7: Writing offset 2 clears each flag bit written 0 and leaves each bit written 1 unchanged.
- R8: `irq` is 1 exactly when some flag bit and the enable bit of the same position at offset 3 are both 1; enable bits exist at [NSRC-1:0] and 7 only, others read 0.
- R9: Offset 4 holds a pointer (PTR_W bits, upper bits read 0); each read or write of offset 5 accesses the memory word at the pointer and then advances it by one, wrapping from MEM_DEPTH-1 to 0.
- R10: With `sleep_mode` 1 (idle) `cpu_wake` equals `irq`; with 2 (power-down) `cpu_wake` is 1 only when enable bit 7 is set and the wake flag or the raw asynchronous capture is set, even with no clock edge in between; with 0 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe, one access per clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| core_evt | input | NSRC | Interrupt event pulses from the USB core |
| bus_activity | input | 1 | Asynchronous wakeup source (line activity) |
| sleep_mode | input | 2 | CPU sleep state: 0 run, 1 idle, 2 power-down |
| irq | output | 1 | Interrupt request |
| cpu_wake | output | 1 | Wake request to the CPU clock controller |
| core_clk | output | 1 | Gated clock for the USB core |

## Verification
A vector table walks register writes and reads in the frozen state and again after unfreeze, which separates the always-reachable window from the core configuration register and exercises pointer increment and wrap. Core events are applied once running and once frozen with disjoint bit patterns, so a single readback shows which pulses were taken. The wake edge is placed mid-cycle and the flag is sampled after the second and third clock edges to pin the synchronizer latency, and the power-down wake is sampled before any edge to show the asynchronous path. The interrupt and wake outputs are checked under enable masks that match and miss the set flags in each sleep mode.

// File: rtl/usbfrz_pkg.sv
package usbfrz_pkg;
  localparam int DATA_W   = 8;
  localparam int WAKE_BIT = 7;

  typedef enum logic [2:0] {
    A_GEN   = 3'd0,
    A_DEV   = 3'd1,
    A_FLAG  = 3'd2,
    A_IEN   = 3'd3,
    A_MADDR = 3'd4,
    A_MDATA = 3'd5,
    A_CORE  = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    SM_RUN   = 2'd0,
    SM_IDLE  = 2'd1,
    SM_PDOWN = 2'd2
  } sleep_e;
endpackage

// File: rtl/usbfrz_clkgate.sv
module usbfrz_clkgate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // transparent while clk is low, so the gate only changes in the low phase
  always_latch begin
    if (!clk) en_lat = en_i;
  end

  assign gclk_o = clk & en_lat;

  // R2: the high phase seen by the core reflects the enable held over the preceding low phase
  a_r2_gate_follows_enable: assert property (@(negedge clk) disable iff (!rst_n)
    gclk_o == $past(en_i));
endmodule

// File: rtl/usbfrz_wake_cap.sv
module usbfrz_wake_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic async_evt,
  output logic raw_o,
  output logic set_pulse_o
);
  logic cap_q;
  logic s1_q, s2_q, clr_q;
  logic clr_n;

  assign clr_n = rst_n & ~clr_q;

  // capture flop clocked by the event itself, works with clk stopped
  always_ff @(posedge async_evt or negedge clr_n) begin
    if (!clr_n) cap_q <= 1'b0;
    else        cap_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      s1_q  <= cap_q;
      s2_q  <= s1_q;
      clr_q <= s2_q;
    end
  end

  assign raw_o       = cap_q;
  assign set_pulse_o = s2_q & ~clr_q;

  // R6: one synchronized event yields exactly one set pulse
  a_r6_single_set_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse_o |=> !set_pulse_o);
endmodule

// File: rtl/usbfrz_regs.sv
module usbfrz_regs
  import usbfrz_pkg::*;
#(
  parameter int NSRC      = 4,
  parameter int MEM_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   core_evt,
  input  logic              wake_set,
  output logic              freeze_o,
  output logic [DATA_W-1:0] flags_o,
  output logic [DATA_W-1:0] ien_o,
  output logic              irq_o
);
  localparam int PTR_W = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
  localparam logic [DATA_W-1:0] IRQ_MASK =
    DATA_W'((1 << WAKE_BIT) | ((1 << NSRC) - 1));
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MEM_DEPTH - 1);

  logic              freeze_q, freeze_d;
  logic [DATA_W-1:0] dev_q, dev_d;
  logic [DATA_W-1:0] flags_q, flags_d;
  logic [DATA_W-1:0] ien_q, ien_d;
  logic [DATA_W-1:0] core_q, core_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [DATA_W-1:0] mem_q [MEM_DEPTH];

  logic wr, mem_acc, mem_wr;
  assign wr      = bus_en & bus_we;
  assign mem_acc = bus_en & (bus_addr == A_MDATA);
  assign mem_wr  = wr & (bus_addr == A_MDATA);

  // next state
  always_comb begin
    freeze_d = freeze_q;
    dev_d    = dev_q;
    ien_d    = ien_q;
    core_d   = core_q;
    ptr_d    = ptr_q;
    flags_d  = flags_q;
    if (wr) begin
      case (bus_addr)
        A_GEN:   freeze_d = bus_wdata[0];
        A_DEV:   dev_d    = bus_wdata;
        A_FLAG:  flags_d  = flags_q & bus_wdata;
        A_IEN:   ien_d    = bus_wdata & IRQ_MASK;
        A_MADDR: ptr_d    = bus_wdata[PTR_W-1:0];
        A_CORE:  if (!freeze_q) core_d = bus_wdata;
        default: ;
      endcase
    end
    if (mem_acc) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
    if (!freeze_q) flags_d[NSRC-1:0] = flags_d[NSRC-1:0] | core_evt;
    if (wake_set)  flags_d[WAKE_BIT] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      dev_q    <= '0;
      flags_q  <= '0;
      ien_q    <= '0;
      core_q   <= '0;
      ptr_q    <= '0;
    end else begin
      freeze_q <= freeze_d;
      dev_q    <= dev_d;
      flags_q  <= flags_d;
      ien_q    <= ien_d;
      core_q   <= core_d;
      ptr_q    <= ptr_d;
    end
  end

  // scratch memory, no reset
  always_ff @(posedge clk) begin
    if (mem_wr) mem_q[ptr_q] <= bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      A_GEN:   bus_rdata = {{(DATA_W-1){1'b0}}, freeze_q};
      A_DEV:   bus_rdata = dev_q;
      A_FLAG:  bus_rdata = flags_q;
      A_IEN:   bus_rdata = ien_q;
      A_MADDR: bus_rdata = DATA_W'(ptr_q);
      A_MDATA: bus_rdata = mem_q[ptr_q];
      A_CORE:  bus_rdata = freeze_q ? '0 : core_q;
      default: bus_rdata = '0;
    endcase
  end

  assign freeze_o = freeze_q;
  assign flags_o  = flags_q;
  assign ien_o    = ien_q;
  assign irq_o    = |(flags_q & ien_q);

  // R5: no core flag rises on the cycle after a frozen cycle
  a_r5_frozen_no_core_set: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q |=> ((flags_q[NSRC-1:0] & ~$past(flags_q[NSRC-1:0])) == '0));

  // R7: writing 0 to the wake bit clears it unless a new wake arrives
  a_r7_zero_clears_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_FLAG && !bus_wdata[WAKE_BIT] && !wake_set) |=> !flags_q[WAKE_BIT]);

  // R4: core configuration is held while frozen
  a_r4_core_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q |=> $stable(core_q));

  // R9: each data access advances the pointer with wrap
  a_r9_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    mem_acc |=> (ptr_q == (($past(ptr_q) == PTR_LAST) ? '0 : $past(ptr_q) + PTR_W'(1))));
endmodule

// File: rtl/usbfrz_ctrl.sv
module usbfrz_ctrl
  import usbfrz_pkg::*;
#(
  parameter int NSRC      = 4,
  parameter int MEM_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   core_evt,
  input  logic              bus_activity,
  input  logic [1:0]        sleep_mode,
  output logic              irq,
  output logic              cpu_wake,
  output logic              core_clk
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              freeze;
  logic              wake_raw, wake_set;
  logic [DATA_W-1:0] flags, ien;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usbfrz_clkgate u_gate (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (~freeze),
    .gclk_o (core_clk)
  );

  usbfrz_wake_cap u_wake (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .async_evt   (bus_activity),
    .raw_o       (wake_raw),
    .set_pulse_o (wake_set)
  );

  usbfrz_regs #(
    .NSRC      (NSRC),
    .MEM_DEPTH (MEM_DEPTH)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .core_evt  (core_evt),
    .wake_set  (wake_set),
    .freeze_o  (freeze),
    .flags_o   (flags),
    .ien_o     (ien),
    .irq_o     (irq)
  );

  always_comb begin
    case (sleep_mode)
      SM_IDLE:  cpu_wake = irq;
      SM_PDOWN: cpu_wake = ien[WAKE_BIT] & (flags[WAKE_BIT] | wake_raw);
      default:  cpu_wake = 1'b0;
    endcase
  end

  // R10: in power-down nothing but an enabled wake source raises the wake request
  a_r10_pdown_wake_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sleep_mode == SM_PDOWN && !ien[WAKE_BIT]) |-> !cpu_wake);

  // R8: no interrupt request while every enable is clear
  a_r8_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ien == '0) |-> !irq);
endmodule

// File: tb/usbfrz_ctrl_tb_top.sv
`timescale 1ns/1ps
module usbfrz_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       bus_en, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] core_evt;
  logic       bus_activity;
  logic [1:0] sleep_mode;
  logic       irq, cpu_wake, core_clk;

  int n_checks;
  int n_errors;
  int gcnt;

  usbfrz_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .core_evt     (core_evt),
    .bus_activity (bus_activity),
    .sleep_mode   (sleep_mode),
    .irq          (irq),
    .cpu_wake     (cpu_wake),
    .core_clk     (core_clk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial gcnt = 0;
  always @(posedge core_clk) gcnt = gcnt + 1;

  // {write, addr[2:0], data[7:0], expected[7:0]}
  localparam int NVEC = 28;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 8'h01, 8'h00},  // freeze
    {1'b1, 3'd1, 8'hA5, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'hA5},  // R3 device ctl frozen
    {1'b1, 3'd3, 8'hFF, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h8F},  // R8 enable mask
    {1'b1, 3'd4, 8'h03, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h03},
    {1'b1, 3'd5, 8'h11, 8'h00},
    {1'b1, 3'd5, 8'h22, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h05},  // R9 two steps
    {1'b1, 3'd4, 8'h03, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'h11},
    {1'b0, 3'd5, 8'h00, 8'h22},
    {1'b0, 3'd4, 8'h00, 8'h05},
    {1'b1, 3'd6, 8'h5A, 8'h00},  // R4 ignored
    {1'b0, 3'd6, 8'h00, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h01},
    {1'b1, 3'd4, 8'h0F, 8'h00},
    {1'b1, 3'd5, 8'h77, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h00},  // R9 wrap
    {1'b1, 3'd4, 8'h0F, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'h77},
    {1'b1, 3'd0, 8'h00, 8'h00},  // unfreeze
    {1'b1, 3'd6, 8'h5A, 8'h00},
    {1'b0, 3'd6, 8'h00, 8'h5A},  // R4 writable when running
    {1'b1, 3'd3, 8'h00, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic gclk_edges(output int n);
    int s;
    @(negedge clk);
    s = gcnt;
    repeat (10) @(posedge clk);
    #1 n = gcnt - s;
  endtask

  task automatic pulse_evt(input logic [3:0] p);
    @(negedge clk);
    core_evt = p;
    @(negedge clk);
    core_evt = '0;
  endtask

  initial begin
    #3000000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int n;
    n_checks = 0; n_errors = 0;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    core_evt = '0; bus_activity = 1'b0; sleep_mode = 2'd0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdchk("R1 gen", 3'd0, 8'h00);
    rdchk("R1 dev", 3'd1, 8'h00);
    rdchk("R1 flags", 3'd2, 8'h00);
    rdchk("R1 ien", 3'd3, 8'h00);
    rdchk("R1 ptr", 3'd4, 8'h00);
    rdchk("R1 core", 3'd6, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 cpu_wake", {7'd0, cpu_wake}, 8'h00);
    gclk_edges(n);
    chk("R1 core_clk running", 8'(n), 8'd10);

    // R3 R4 R9 vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else rdchk($sformatf("R3_R4_R9 vector %0d", i), VEC[i][18:16], VEC[i][7:0]);
    end

    // R2 gating
    wr(3'd0, 8'hFF);
    rdchk("R2 only freeze bit", 3'd0, 8'h01);
    gclk_edges(n);
    chk("R2 frozen edges", 8'(n), 8'd0);
    wr(3'd0, 8'h00);
    gclk_edges(n);
    chk("R2 unfrozen edges", 8'(n), 8'd10);

    // R5 core events
    pulse_evt(4'b0101);
    rdchk("R5 running events", 3'd2, 8'h05);
    wr(3'd0, 8'h01);
    pulse_evt(4'b1010);
    rdchk("R5 frozen events ignored", 3'd2, 8'h05);

    // R6 wake latency while frozen
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd2;
    bus_activity = 1'b1;
    #2 bus_activity = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 chk("R6 not yet after two edges", {7'd0, bus_rdata[7]}, 8'h00);
    @(posedge clk);
    #1 chk("R6 set on third edge", {7'd0, bus_rdata[7]}, 8'h01);
    @(negedge clk) bus_en = 1'b0;
    repeat (4) @(negedge clk);
    rdchk("R6 flag held", 3'd2, 8'h85);

    // R7 write-zero-to-clear
    wr(3'd2, 8'hFF);
    rdchk("R7 ones keep", 3'd2, 8'h85);
    wr(3'd2, 8'hFE);
    rdchk("R7 zero clears", 3'd2, 8'h84);

    // R8 irq masking (flags = 0x84)
    @(negedge clk) #1;
    chk("R8 no enables", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h04);
    #1 chk("R8 core bit enabled", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h02);
    #1 chk("R8 mismatched enable", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h80);
    #1 chk("R8 wake enabled", {7'd0, irq}, 8'h01);

    // R10 sleep modes
    sleep_mode = 2'd2; #1 chk("R10 pdown wake enabled", {7'd0, cpu_wake}, 8'h01);
    sleep_mode = 2'd1; #1 chk("R10 idle follows irq", {7'd0, cpu_wake}, 8'h01);
    sleep_mode = 2'd0; #1 chk("R10 run no wake", {7'd0, cpu_wake}, 8'h00);
    wr(3'd3, 8'h04);
    sleep_mode = 2'd2; #1 chk("R10 pdown ignores core irq", {7'd0, cpu_wake}, 8'h00);
    sleep_mode = 2'd1; #1 chk("R10 idle core irq", {7'd0, cpu_wake}, 8'h01);

    // R10 asynchronous wake in power-down
    wr(3'd3, 8'h80);
    wr(3'd2, 8'h7F);
    sleep_mode = 2'd2;
    #1 chk("R10 pdown cleared", {7'd0, cpu_wake}, 8'h00);
    @(negedge clk);
    bus_activity = 1'b1;
    #2 chk("R10 async wake before edge", {7'd0, cpu_wake}, 8'h01);
    bus_activity = 1'b0;
    repeat (5) @(negedge clk);
    #1 chk("R10 wake held by flag", {7'd0, cpu_wake}, 8'h01);
    rdchk("R6 flag from pdown edge", 3'd2, 8'h84);
    sleep_mode = 2'd0;
    wr(3'd0, 8'h00);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule